// File: doc/BRIEF.md
# CCD Pixel Sampling Timing Sequencer

This block generates the per-pixel control pulses that a CCD digitizer front end needs. It runs from the system clock. For each pixel it produces an optional reset/black-level clamp pulse, then a video-sample pulse whose falling edge starts an analog conversion, and then a one-cycle strobe that tells the readout logic a conversion is under way. The first pixel of each line also carries a start-of-line marker. With that marker the clamp can fire on every pixel, for correlated double sampling, or only once per line, for optical-black restore.

Software gives the pixel period, the clamp width, the sample width and the pulse gap as system-clock counts. The block takes each value as the larger of the request and the count that meets the analog minimum time at the configured clock frequency, rounding up. The period is held inside the allowed pixel-rate band and stretched when the pulses would not fit. All settings are captured together at a line boundary, so a line never mixes two configurations. Starting and stopping also happen only at line boundaries, so no pulse is ever cut short.

Top module: `ccd_pix_seq`

## Requirements
- R1: The pixel period used is the requested period saturated to [ceil(CLK_HZ/1e6), floor(CLK_HZ/1000)] cycles, which is [50, 50000] at 50 MHz. It is then raised, if needed, to clamp width + gap + sample width + max(gap, quiet + 1). Consecutive sample pulses in a line start exactly one period apart.
- R2: The clamp pulse is high for exactly max(requested width, ceil(300 ns × CLK_HZ)) cycles, which is at least 15 at 50 MHz. Every width is capped at floor(CLK_HZ/1000)/4 cycles.
- R3: The sample pulse is high for exactly max(requested width, ceil(500 ns × CLK_HZ)) cycles, which is at least 25 at 50 MHz.
- R4: The gap is max(requested gap, ceil(50 ns × CLK_HZ)) cycles, which is at least 3 at 50 MHz. The sample pulse rises exactly one gap after the clamp falls. The next clamp never rises less than one gap after the sample falls.
- R5: With line_mode = 1 the clamp fires only on the first pixel of a line. With line_mode = 0 it fires on every pixel. In both modes the sample rises clamp width + gap cycles after the pixel start.
- R6: On the cycle the sample pulse falls, and for ceil(20 ns × CLK_HZ) − 1 further cycles, no other output changes.
- R7: conv_start is high for exactly one cycle, ceil(20 ns × CLK_HZ) cycles after the sample pulse falls. That is the cycle after its first low cycle at 50 MHz. It fires once per pixel.
- R8: Configuration inputs are captured only when a line starts. Changes made mid-line take effect on the next line.
- R9: line_start is high for one cycle at the start of the first pixel of every line, in the same cycle the clamp rises. It is never high on other pixels.
- R10: A high run starts a line when the block is idle. run is otherwise looked at only at the end of a line: if it is low there, the block goes idle after completing that line, with all outputs low.
- R11: During and after reset, until run starts a line, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Request to produce lines |
| period_req | input | 20 | Requested pixel period in clocks |
| clamp_req | input | 20 | Requested clamp width in clocks |
| sample_req | input | 20 | Requested sample width in clocks |
| gap_req | input | 20 | Requested clamp/sample separation in clocks |
| line_mode | input | 1 | 1: clamp once per line; 0: clamp every pixel |
| line_len | input | 16 | Pixels per line (0 treated as 1) |
| clamp_o | output | 1 | Black/reset-level clamp pulse |
| sample_o | output | 1 | Video-sample pulse; falling edge starts conversion |
| conv_start | output | 1 | One-cycle conversion-started strobe |
| line_start | output | 1 | Start-of-line marker |

## Verification
The pulse sequence is tried with comfortable values in per-pixel clamp mode and in once-per-line mode. Comparing the two shows whether the mode changes only clamp presence and leaves the sample timing alone. It is also tried with requests below every minimum, where widths and period must round up, and with widths whose sum exceeds the requested period, where the period must stretch. A period above the slowest allowed rate checks saturation. A mid-line switch to a different configuration and mode shows whether settings apply per line rather than immediately. Stopping in the middle of a line shows that the line finishes and nothing follows.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  localparam int TW = 20;   // timing count width
  localparam int LW = 16;   // pixels-per-line width

  typedef logic [TW-1:0] tick_t;

  typedef struct packed {
    tick_t          per;
    tick_t          clamp_w;
    tick_t          samp_w;
    tick_t          gap;
    logic           line_mode;
    logic [LW-1:0]  line_len;
  } timing_t;

  // Cycles needed to cover ns nanoseconds, rounded up.
  function automatic int unsigned ns_to_cyc(int unsigned ns, longint unsigned clk_hz);
    longint unsigned prod;
    prod = longint'(ns) * clk_hz;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

  function automatic int unsigned fit_range(int unsigned v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  // Shortest pixel that holds every pulse, its trailing gap and the strobe.
  function automatic int unsigned pixel_span(int unsigned cw, int unsigned g,
                                             int unsigned sw, int unsigned q);
    int unsigned tail;
    tail = (g > q + 1) ? g : q + 1;
    return cw + g + sw + tail;
  endfunction

endpackage

// File: rtl/ccd_seq_fit.sv
module ccd_seq_fit
  import ccd_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000
) (
  input  tick_t         period_req,
  input  tick_t         clamp_req,
  input  tick_t         sample_req,
  input  tick_t         gap_req,
  input  logic          line_mode,
  input  logic [LW-1:0] line_len,
  output timing_t       fit
);
  localparam int unsigned MIN_CLAMP = ns_to_cyc(300, CLK_HZ);
  localparam int unsigned MIN_SAMP  = ns_to_cyc(500, CLK_HZ);
  localparam int unsigned MIN_GAP   = ns_to_cyc(50, CLK_HZ);
  localparam int unsigned QUIET     = ns_to_cyc(20, CLK_HZ);
  localparam int unsigned MIN_PER   = ns_to_cyc(1000, CLK_HZ);
  localparam int unsigned MAX_PER   = int'(CLK_HZ / 1000);
  localparam int unsigned MAX_W     = MAX_PER / 4;

  int unsigned cw, sw, g, p, span;

  always_comb begin
    cw   = fit_range(int'(clamp_req), MIN_CLAMP, MAX_W);
    sw   = fit_range(int'(sample_req), MIN_SAMP, MAX_W);
    g    = fit_range(int'(gap_req), MIN_GAP, MAX_W);
    span = pixel_span(cw, g, sw, QUIET);
    p    = fit_range(int'(period_req), MIN_PER, MAX_PER);
    if (p < span) p = span;
    fit.per       = tick_t'(p);
    fit.clamp_w   = tick_t'(cw);
    fit.samp_w    = tick_t'(sw);
    fit.gap       = tick_t'(g);
    fit.line_mode = line_mode;
    fit.line_len  = (line_len == '0) ? LW'(1) : line_len;
  end

endmodule

// File: rtl/ccd_seq_count.sv
module ccd_seq_count
  import ccd_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    run,
  input  timing_t fit,
  output logic    active,
  output tick_t   cnt,
  output logic    first_px,
  output timing_t cfg
);
  localparam int unsigned MIN_PER = ns_to_cyc(1000, CLK_HZ);
  localparam int unsigned MAX_PER = int'(CLK_HZ / 1000);

  logic [LW-1:0] px;
  logic          pix_end, line_end;

  assign pix_end  = active && (cnt == cfg.per - 1'b1);
  assign line_end = pix_end && (px == cfg.line_len - 1'b1);
  assign first_px = (px == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      px     <= '0;
      cfg    <= '0;
    end else if (!active) begin
      if (run) begin
        active <= 1'b1;
        cfg    <= fit;
        cnt    <= '0;
        px     <= '0;
      end
    end else if (pix_end) begin
      cnt <= '0;
      if (line_end) begin
        px <= '0;
        if (run) cfg <= fit;
        else     active <= 1'b0;
      end else begin
        px <= px + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r1_period_range: assert property (@(posedge clk) disable iff (rst)
    active |-> (cfg.per >= tick_t'(MIN_PER) && cfg.per <= tick_t'(MAX_PER) && cnt < cfg.per));

  a_r8_cfg_held_in_line: assert property (@(posedge clk) disable iff (rst)
    (active && !(cnt == '0 && px == '0)) |-> $stable(cfg));

endmodule

// File: rtl/ccd_seq_pulse.sv
module ccd_seq_pulse
  import ccd_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    active,
  input  tick_t   cnt,
  input  logic    first_px,
  input  timing_t cfg,
  output logic    clamp_o,
  output logic    sample_o,
  output logic    conv_start,
  output logic    line_start
);
  localparam int unsigned MIN_CLAMP = ns_to_cyc(300, CLK_HZ);
  localparam int unsigned MIN_SAMP  = ns_to_cyc(500, CLK_HZ);
  localparam int unsigned MIN_GAP   = ns_to_cyc(50, CLK_HZ);
  localparam int unsigned QUIET     = ns_to_cyc(20, CLK_HZ);

  tick_t samp_on, samp_off, conv_at;
  logic  clamp_this_px, want_clamp, want_samp, want_conv, want_sol;

  always_comb begin
    samp_on       = cfg.clamp_w + cfg.gap;
    samp_off      = samp_on + cfg.samp_w;
    conv_at       = samp_off + tick_t'(QUIET);
    clamp_this_px = !cfg.line_mode || first_px;
    want_clamp    = active && clamp_this_px && (cnt < cfg.clamp_w);
    want_samp     = active && (cnt >= samp_on) && (cnt < samp_off);
    want_conv     = active && (cnt == conv_at);
    want_sol      = active && first_px && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_o    <= 1'b0;
      sample_o   <= 1'b0;
      conv_start <= 1'b0;
      line_start <= 1'b0;
    end else begin
      clamp_o    <= want_clamp;
      sample_o   <= want_samp;
      conv_start <= want_conv;
      line_start <= want_sol;
    end
  end

  // Run-length and distance counters observed by the assertions below.
  tick_t clamp_run, samp_run, since_cf, since_sf;
  localparam tick_t SAT = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_run <= '0;
      samp_run  <= '0;
      since_cf  <= SAT;
      since_sf  <= SAT;
    end else begin
      clamp_run <= clamp_o ? clamp_run + 1'b1 : '0;
      samp_run  <= sample_o ? samp_run + 1'b1 : '0;
      since_cf  <= clamp_o ? '0 : ((since_cf == SAT) ? SAT : since_cf + 1'b1);
      since_sf  <= sample_o ? '0 : ((since_sf == SAT) ? SAT : since_sf + 1'b1);
    end
  end

  a_r2_clamp_width: assert property (@(posedge clk) disable iff (rst)
    $fell(clamp_o) |-> (clamp_run >= tick_t'(MIN_CLAMP)));

  a_r3_sample_width: assert property (@(posedge clk) disable iff (rst)
    $fell(sample_o) |-> (samp_run >= tick_t'(MIN_SAMP)));

  a_r4_gap_clamp_to_sample: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_o) |-> (since_cf >= tick_t'(MIN_GAP)));

  a_r4_gap_sample_to_clamp: assert property (@(posedge clk) disable iff (rst)
    $rose(clamp_o) |-> (since_sf >= tick_t'(MIN_GAP)));

  a_r5_clamp_once_per_line: assert property (@(posedge clk) disable iff (rst)
    ($rose(clamp_o) && cfg.line_mode) |-> first_px);

  a_r6_quiet_window: assert property (@(posedge clk) disable iff (rst)
    (!sample_o && since_sf < tick_t'(QUIET)) |->
      ($stable(clamp_o) && $stable(line_start) && $stable(conv_start)));

  a_r7_conv_delay: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start) |-> (since_sf == tick_t'(QUIET)));

  a_r7_conv_single: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);

  a_r9_sol_with_clamp: assert property (@(posedge clk) disable iff (rst)
    line_start |-> clamp_o);

endmodule

// File: rtl/ccd_pix_seq.sv
module ccd_pix_seq
  import ccd_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 50_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [19:0]   period_req,
  input  logic [19:0]   clamp_req,
  input  logic [19:0]   sample_req,
  input  logic [19:0]   gap_req,
  input  logic          line_mode,
  input  logic [15:0]   line_len,
  output logic          clamp_o,
  output logic          sample_o,
  output logic          conv_start,
  output logic          line_start
);
  timing_t fit, cfg;
  logic    active, first_px;
  tick_t   cnt;

  ccd_seq_fit #(.CLK_HZ(CLK_HZ)) u_fit (
    .period_req (period_req),
    .clamp_req  (clamp_req),
    .sample_req (sample_req),
    .gap_req    (gap_req),
    .line_mode  (line_mode),
    .line_len   (line_len),
    .fit        (fit)
  );

  ccd_seq_count #(.CLK_HZ(CLK_HZ)) u_count (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .fit      (fit),
    .active   (active),
    .cnt      (cnt),
    .first_px (first_px),
    .cfg      (cfg)
  );

  ccd_seq_pulse #(.CLK_HZ(CLK_HZ)) u_pulse (
    .clk        (clk),
    .rst        (rst),
    .active     (active),
    .cnt        (cnt),
    .first_px   (first_px),
    .cfg        (cfg),
    .clamp_o    (clamp_o),
    .sample_o   (sample_o),
    .conv_start (conv_start),
    .line_start (line_start)
  );

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!clamp_o && !sample_o && !conv_start && !line_start));

endmodule

// File: tb/test_ccd_pix_seq.sv
module test_ccd_pix_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [19:0] period_req = '0, clamp_req = '0, sample_req = '0, gap_req = '0;
  logic        line_mode = 1'b0;
  logic [15:0] line_len = 16'd1;
  logic        clamp_o, sample_o, conv_start, line_start;

  always #10 clk = ~clk;   // 50 MHz

  ccd_pix_seq i_ccd_pix_seq (
    .clk(clk), .rst(rst), .run(run),
    .period_req(period_req), .clamp_req(clamp_req),
    .sample_req(sample_req), .gap_req(gap_req),
    .line_mode(line_mode), .line_len(line_len),
    .clamp_o(clamp_o), .sample_o(sample_o),
    .conv_start(conv_start), .line_start(line_start)
  );

  typedef struct {
    int per; int cw; int sw; int g; bit lmode; int len;
  } cfg_s;

  typedef struct {
    bit clamp; bit sol; int per; int cw; int sw; int g;
  } item_s;

  item_s exp_q[$];
  int checks = 0, errors = 0;
  int conv_seen = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Expected timing at 50 MHz: 20 ns per clock.
  function automatic cfg_s settle(cfg_s r);
    cfg_s o;
    int tail, need;
    o = r;
    o.cw  = (r.cw < 15) ? 15 : ((r.cw > 12500) ? 12500 : r.cw);
    o.sw  = (r.sw < 25) ? 25 : ((r.sw > 12500) ? 12500 : r.sw);
    o.g   = (r.g  < 3)  ? 3  : ((r.g  > 12500) ? 12500 : r.g);
    tail  = (o.g > 2) ? o.g : 2;
    need  = o.cw + o.g + o.sw + tail;
    o.per = r.per;
    if (o.per > 50000) o.per = 50000;
    if (o.per < 50) o.per = 50;
    if (o.per < need) o.per = need;
    o.len = (r.len == 0) ? 1 : r.len;
    return o;
  endfunction

  task automatic push_line(cfg_s c);
    for (int i = 0; i < c.len; i++) begin
      item_s it;
      it.clamp = !c.lmode || (i == 0);
      it.sol = (i == 0);
      it.per = c.per; it.cw = c.cw; it.sw = c.sw; it.g = c.g;
      exp_q.push_back(it);
    end
  endtask

  task automatic apply(cfg_s r);
    period_req = 20'(r.per); clamp_req = 20'(r.cw);
    sample_req = 20'(r.sw);  gap_req = 20'(r.g);
    line_mode = r.lmode;     line_len = 16'(r.len);
  endtask

  // Line 1 uses a, later lines use b (switched mid-line 1); run drops inside the last line.
  task automatic run_lines(cfg_s a, cfg_s b, int n);
    cfg_s fa, fb;
    int base, stop_at;
    fa = settle(a); fb = settle(b);
    push_line(fa);
    for (int l = 1; l < n; l++) push_line(fb);
    base = conv_seen;
    stop_at = base + fa.len + (n - 2) * fb.len + 1;
    if (n == 1) stop_at = base + 1;
    @(negedge clk);
    apply(a);
    run = 1'b1;
    while (conv_seen < base + 1) @(negedge clk);
    apply(b);
    while (conv_seen < stop_at) @(negedge clk);
    run = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2 * fb.per + 20) @(negedge clk);
    chk(!clamp_o && !sample_o && !conv_start && !line_start, "R10",
        "outputs idle after stop", {clamp_o, sample_o, conv_start, line_start}, 0);
    chk(conv_seen == base + fa.len + (n - 1) * fb.len, "R10",
        "pixels produced", conv_seen - base, fa.len + (n - 1) * fb.len);
  endtask

  // Monitor / scoreboard
  longint t = 0;
  longint t_cr = 0, t_cf = 0, t_sr = 0, t_sf = 0, last_sr = 0;
  bit pc = 0, ps = 0, pcv = 0, psl = 0, cl_seen = 0, sol_seen = 0, have_last = 0;

  always @(negedge clk) begin
    t++;
    if (!rst) begin
      if (clamp_o && !pc) begin t_cr = t; cl_seen = 1; end
      if (!clamp_o && pc) t_cf = t;
      if (line_start) begin
        sol_seen = 1;
        chk(clamp_o && !pc, "R9", "line_start with clamp rise", clamp_o, 1);
      end
      if (sample_o && !ps) t_sr = t;
      if (!sample_o && ps) begin
        t_sf = t;
        chk(clamp_o == pc && line_start == psl && conv_start == pcv, "R6",
            "other output toggled at sample fall", 1, 0);
      end
      if (conv_start && !pcv) begin
        conv_seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected pixel", 1, 0);
        end else begin
          item_s e;
          e = exp_q.pop_front();
          chk(int'(t - t_sf) == 1, "R7", "strobe delay", int'(t - t_sf), 1);
          chk(int'(t_sf - t_sr) == e.sw, "R3", "sample width", int'(t_sf - t_sr), e.sw);
          chk(cl_seen == e.clamp, "R5", "clamp presence", cl_seen, e.clamp);
          chk(sol_seen == e.sol, "R9", "line_start presence", sol_seen, e.sol);
          if (e.clamp && cl_seen) begin
            chk(int'(t_cf - t_cr) == e.cw, "R2", "clamp width", int'(t_cf - t_cr), e.cw);
            chk(int'(t_sr - t_cf) == e.g, "R4", "clamp-to-sample gap", int'(t_sr - t_cf), e.g);
          end
          if (!e.sol && have_last)
            chk(int'(t_sr - last_sr) == e.per, "R1", "pixel period", int'(t_sr - last_sr), e.per);
          if (e.sol && e.clamp != cl_seen) ;
        end
        last_sr = t_sr; have_last = 1;
        cl_seen = 0; sol_seen = 0;
      end
      if (conv_start && pcv) chk(0, "R7", "strobe longer than one cycle", 2, 1);
    end
    pc = clamp_o; ps = sample_o; pcv = conv_start; psl = line_start;
  end

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    cfg_s cds, lin, mins, wide, big, swb;
    cds  = '{per:100, cw:20, sw:30, g:5, lmode:0, len:3};
    lin  = '{per:120, cw:16, sw:26, g:4, lmode:1, len:4};
    mins = '{per:10, cw:1, sw:1, g:0, lmode:0, len:2};
    wide = '{per:60, cw:40, sw:40, g:10, lmode:0, len:2};
    swb  = '{per:80, cw:18, sw:28, g:6, lmode:1, len:2};
    big  = '{per:60000, cw:20, sw:30, g:5, lmode:0, len:2};

    repeat (4) @(negedge clk);
    // R11: reset state
    chk(!clamp_o && !sample_o && !conv_start && !line_start, "R11", "outputs in reset",
        {clamp_o, sample_o, conv_start, line_start}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(!clamp_o && !sample_o && !conv_start && !line_start, "R11", "outputs idle before run",
        {clamp_o, sample_o, conv_start, line_start}, 0);

    run_lines(cds, cds, 2);     // R2 R3 R4 R5 per pixel
    run_lines(lin, lin, 2);     // R5 once per line
    run_lines(mins, mins, 1);   // R2 R3 R4 R1 minimum rounding
    run_lines(wide, wide, 1);   // R1 stretched period
    run_lines(cds, swb, 3);     // R8 mid-line change applies next line
    run_lines(big, big, 1);     // R1 saturation to slowest rate

    done = 1;
    finish_up();
  end

endmodule